// File: doc/BRIEF.md
# Grouped Carry-Select Adder

This block is a purely combinational binary adder. Two operands and a carry-in produce a sum of the same width and a carry-out. The operand width is split into equal groups. The lowest group is one ripple-carry chain of full adders, fed directly by the real carry-in. Every higher group holds two ripple chains of its own. One chain works as if its carry-in were 0 and the other as if it were 1, so both candidate results are ready before the true carry into that group is known.

When the true carry reaches an upper group, it selects that group's sum slice and also its carry-out, and that carry-out then drives the selection in the next group. The carry therefore crosses each group boundary through one select stage and does not ripple through the group's bits. With the default 16-bit width and 4-bit groups, the adder holds seven 4-bit ripple chains: one for the lowest group and two for each of the three upper groups. The block is meant to sit between registers in a larger datapath. It has no state of its own.

Top module: `grouped_select_adder`

## Requirements
- R1: For all inputs, `{cout, sum}` equals `a + b + cin` computed at full precision, with `cout` as bit 16 of the 17-bit result.
- R2: The lowest 4-bit slice of `sum` (bits 3:0) equals the low four bits of `a[3:0] + b[3:0] + cin`, for all 512 combinations of those inputs.
- R3: Each 4-bit ripple chain yields `{carry, sum}` equal to the arithmetic sum of its two 4-bit operands and its carry-in.
- R4: A carry that is created in the lowest group reaches `cout` through all four groups: `0xFFFF + 0x0001` with `cin=0` gives `sum=0x0000` and `cout=1`, and `0xFFFF + 0x0000` with `cin=1` gives the same result.
- R5: In each upper group, a carry from the carry-in-0 chain implies a carry from the carry-in-1 chain. The group's carry-out equals the carry-in-0 carry OR (the carry-in-1 carry AND the true incoming carry).
- R6: In each upper group, the sum slice of the carry-in-1 chain equals the sum slice of the carry-in-0 chain plus one, modulo 16. The group outputs the carry-in-1 slice when its true incoming carry is 1 and the carry-in-0 slice when it is 0.
- R7: A carry out of the top bit alone sets `cout`: `0x8000 + 0x8000` with `cin=0` gives `sum=0x0000` and `cout=1`, and all-zero inputs give `sum=0x0000` and `cout=0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum modulo 2^16 |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Whenever the inputs are known, the assertions check the arithmetic of every ripple chain, the ordering between the two candidate carries in each upper group, the plus-one relation between the two candidate sum slices, and the full-width result. These checks cannot show that a carry created in the lowest group really crosses all three select stages. Only the bench's directed patterns show this, such as all-ones plus one and a carry produced in the top bit alone, together with the exhaustive sweep of the lowest group against the carry-in. A long pseudo-random run then drives each group with both values of its incoming carry.

// File: rtl/csa_pkg.sv
// Package: shared sizing for the grouped carry-select adder.
// Assumes the data width is a whole multiple of the group width.
package csa_pkg;
    parameter int unsigned DEF_DATA_W  = 16;
    parameter int unsigned DEF_GROUP_W = 4;
endpackage

// File: rtl/csa_full_add.sv
// Module: one-bit full adder; the building cell of every ripple chain.
// Assumes nothing beyond single-bit inputs; purely combinational.
module csa_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    // Sum bit and carry out from generate / propagate terms.
    always_comb begin
        half = x ^ y;
        s    = half ^ ci;
        co   = (x & y) | (ci & half);
    end
endmodule

// File: rtl/csa_ripple_slice.sv
// Module: W-bit ripple-carry chain; the carry out of each bit feeds the next bit.
// Assumes W >= 1; purely combinational.
module csa_ripple_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            csa_full_add u_fa (
                .x (x[i]),
                .y (y[i]),
                .ci(chain[i]),
                .s (s[i]),
                .co(chain[i+1])
            );
        end
    endgenerate

    assign co = chain[W];

    // Check the chain against arithmetic whenever inputs are known.
    always_comb begin
        if (!$isunknown({x, y, ci})) begin
            // R3
            slice_arith_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}))
                else $error("ripple slice arithmetic mismatch");
        end
    end
endmodule

// File: rtl/csa_select_group.sv
// Module: one upper group; two ripple chains precompute carry-in 0 and 1, the true carry picks.
// Assumes the incoming carry comes from the group below; purely combinational.
module csa_select_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          ci,
    output logic [GW-1:0] s,
    output logic          co
);
    logic [GW-1:0] s_zero;
    logic [GW-1:0] s_one;
    logic          c_zero;
    logic          c_one;

    csa_ripple_slice #(.W(GW)) u_assume0 (
        .x (x),
        .y (y),
        .ci(1'b0),
        .s (s_zero),
        .co(c_zero)
    );

    csa_ripple_slice #(.W(GW)) u_assume1 (
        .x (x),
        .y (y),
        .ci(1'b1),
        .s (s_one),
        .co(c_one)
    );

    // Select the sum slice and carry out with the true incoming carry.
    always_comb begin
        s  = ci ? s_one : s_zero;
        co = c_zero | (c_one & ci);
    end

    // Guard the relations between the two candidate results.
    always_comb begin
        if (!$isunknown({x, y, ci})) begin
            // R5
            carry_order_chk: assert (!c_zero || c_one)
                else $error("assume-0 carry without assume-1 carry");
            // R6
            sum_step_chk: assert (s_one == GW'(s_zero + 1'b1))
                else $error("assume-1 sum is not assume-0 sum plus one");
            // R5
            group_out_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{GW{1'b0}}, ci}))
                else $error("selected group result mismatch");
        end
    end
endmodule

// File: rtl/grouped_select_adder.sv
// Module: top of the grouped carry-select adder.
// The lowest group is a single ripple chain on the real carry-in; upper groups are select groups.
// Assumes DATA_W is a multiple of GROUP_W; purely combinational, no reset needed.
module grouped_select_adder
    import csa_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned GROUP_W = DEF_GROUP_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    localparam int unsigned NGRP = DATA_W / GROUP_W;

    logic [NGRP:0] gcarry;

    assign gcarry[0] = cin;

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            if (g == 0) begin : g_low
                csa_ripple_slice #(.W(GROUP_W)) u_low (
                    .x (a[GROUP_W-1:0]),
                    .y (b[GROUP_W-1:0]),
                    .ci(gcarry[0]),
                    .s (sum[GROUP_W-1:0]),
                    .co(gcarry[1])
                );
            end else begin : g_up
                csa_select_group #(.GW(GROUP_W)) u_sel (
                    .x (a[g*GROUP_W +: GROUP_W]),
                    .y (b[g*GROUP_W +: GROUP_W]),
                    .ci(gcarry[g]),
                    .s (sum[g*GROUP_W +: GROUP_W]),
                    .co(gcarry[g+1])
                );
            end
        end
    endgenerate

    assign cout = gcarry[NGRP];

    // Whole-width result against arithmetic whenever inputs are known.
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            // R1
            full_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin}))
                else $error("full-width sum mismatch");
        end
    end
endmodule

// File: tb/grouped_select_adder_test.sv
module grouped_select_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    grouped_select_adder uut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    // Drive at the falling edge, compare halfway to the rising edge.
    task automatic apply(input logic [15:0] av, input logic [15:0] bv,
                         input logic ci, input string req);
        int unsigned ref_total;
        @(negedge clk);
        a = av; b = bv; cin = ci;
        #5;
        ref_total = int'(av) + int'(bv) + int'(ci);
        n_cmp++;
        if ({cout, sum} !== 17'(ref_total)) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h cin=%b actual=%b_%h expected=%b_%h",
                     req, av, bv, ci, cout, sum, ref_total[16], ref_total[15:0]);
        end
    endtask

    // Exhaustive sweep of the lowest group, low nibble compared separately.
    task automatic low_nibble(input logic [3:0] av, input logic [3:0] bv, input logic ci);
        int unsigned ref_low;
        apply({12'h5A3, av}, {12'h0C6, bv}, ci, "R1");
        ref_low = (int'(av) + int'(bv) + int'(ci)) % 16;
        n_cmp++;
        if (sum[3:0] !== 4'(ref_low)) begin
            n_bad++;
            $display("FAIL R2: actual=%h expected=%h", sum[3:0], ref_low[3:0]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R7: all-zero inputs give zero
        apply(16'h0000, 16'h0000, 1'b0, "R7");
        // R4: carry runs through every group
        apply(16'hFFFF, 16'h0001, 1'b0, "R4");
        apply(16'hFFFF, 16'h0000, 1'b1, "R4");
        apply(16'h0001, 16'hFFFF, 1'b1, "R4");
        // R7: carry out of top bit only
        apply(16'h8000, 16'h8000, 1'b0, "R7");
        apply(16'h7FFF, 16'h0000, 1'b1, "R1");
        // R5 and R6: each upper group sees both incoming carry values
        for (int k = 1; k < 4; k++) begin
            logic [15:0] below_ones;
            below_ones = 16'((32'h1 << (4 * k)) - 1);
            apply(below_ones, 16'h0001, 1'b0, "R5");
            apply(below_ones | 16'(32'hF << (4 * k)), 16'h0001, 1'b0, "R6");
            apply(16'(32'h9 << (4 * k)), 16'(32'h6 << (4 * k)), 1'b0, "R6");
            apply(16'(32'h9 << (4 * k)) | below_ones, 16'(32'h6 << (4 * k)), 1'b1, "R5");
        end
        // R2 and R3: every lowest-group input combination
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++)
                    low_nibble(4'(x), 4'(y), 1'(c));
        // R1: pseudo-random operands
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[15:0], lfsr[31:16], lfsr[7], "R1");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule